// File: doc/BRIEF.md
# Coincidence Trigger Selection Unit

This block turns logic pulses from two detector channels into an experiment trigger. One channel carries a fast timing pulse from a focal-plane detector. The other carries a pulse from a secondary detector near the target. Both inputs are synchronised to the block clock and edge-detected. Three trigger sources can be enabled in any combination:

- focal-plane singles, thinned by a programmable downscaler;
- secondary singles;
- the coincidence of the two channels, taken when their stretched windows overlap.

The enabled sources are ORed onto a raw trigger output.

A raw trigger that arrives while the unit is idle becomes a live trigger. On that clock edge the unit latches two things: a bit pattern of the sources that fired within the coincidence window, and a free-running timestamp. It then holds busy until the acquisition acknowledges. While busy, the readout port presents a packet of five 16-bit words, advanced by a next strobe:

- a fixed tag 0x2367;
- the source pattern;
- the timestamp, most significant word first.

Event counters for each input and for raw triggers help account for events that produce several raw pulses.

Top module: `coinc_trigger_unit`

## Requirements
- R1: A raw trigger pulse appears only for a source whose bit in `cfg_src_en` is set. With all enables clear, no input activity produces a raw trigger.
- R2: The coincidence source fires once when the two stretched channel windows begin to overlap. Each window lasts `cfg_window` cycles (0 behaves as 1). Pulses whose windows do not overlap give no coincidence.
- R3: The focal-plane singles source passes one pulse in N, where N is `cfg_downscale`. The internal count carries over across changes of N. A pulse passes when count+1 >= N, which resets the count; otherwise the count increments. Values 0 and 1 pass every pulse.
- R4: `live_trig_o` pulses with `raw_trig_o` exactly when busy was low, and it sets `busy_o`. A raw trigger during busy changes neither the latched pattern nor the latched timestamp.
- R5: `busy_o` stays high until `rd_ack_i` is sampled high, and is low on the following cycle.
- R6: The pattern word holds downscaled singles in bit 0, secondary singles in bit 1 and coincidence in bit 2, with the upper bits zero. A bit is set if its source fired at the live trigger or within the window before it.
- R7: While busy, the readout words come in a fixed order. Word 0 is 0x2367, word 1 is the pattern, and words 2, 3 and 4 are timestamp bits 47:32, 31:16 and 15:0. Each `rd_next_i` advances one word, stopping at the last word.
- R8: The timestamp is a 48-bit count of clock edges since reset. It is latched on the edge that raises `live_trig_o` and holds the count before that edge.
- R9: `cnt_fp_o` and `cnt_sec_o` count rising edges on the two inputs. `cnt_raw_o` counts raw trigger pulses.
- R10: After reset, busy, raw, live and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_pulse_i | input | 1 | Focal-plane timing pulse (asynchronous) |
| sec_pulse_i | input | 1 | Secondary detector pulse (asynchronous) |
| cfg_src_en | input | 3 | Source enables: bit0 downscaled singles, bit1 secondary, bit2 coincidence |
| cfg_window | input | WIN_W | Coincidence window in cycles |
| cfg_downscale | input | DS_W | Singles downscale factor |
| rd_next_i | input | 1 | Advance to next readout word |
| rd_ack_i | input | 1 | Readout done, clears busy |
| raw_trig_o | output | 1 | OR of enabled sources |
| live_trig_o | output | 1 | Raw trigger accepted while idle |
| busy_o | output | 1 | Event latched, awaiting acknowledge |
| rd_data_o | output | RD_W | Current readout word |
| cnt_fp_o | output | CNT_W | Focal-plane input edge count |
| cnt_sec_o | output | CNT_W | Secondary input edge count |
| cnt_raw_o | output | CNT_W | Raw trigger pulse count |

## Verification
The assertions take for granted that `rd_ack_i` is raised only while the acquisition treats the unit as busy. They also assume that the source enables are held steady for a cycle around each pulse, so that a raw pulse can be traced to the enables of the cycle before. The stimulus keeps the detector pulses one clock wide and at least three cycles apart, which keeps every edge visible after synchronisation. It changes enables and downscale factors only while the inputs are quiet, and acknowledges only after reading a packet. Random downscale factors from 0 to 5 and random burst lengths are mixed with directed coincidence orderings, out-of-window pairs and triggers that arrive during busy.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_DS  = 0;
  localparam int SRC_SEC = 1;
  localparam int SRC_CO  = 2;
  localparam logic [15:0] PKT_TAG = 16'h2367;
endpackage

// File: rtl/ctu_pulse_in.sv
// Synchroniser followed by a rising-edge detector.
module ctu_pulse_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pulse_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ctu_stretch.sv
// Holds active_o for win_i cycles (minimum 1) after each trigger; retriggerable.
module ctu_stretch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig_i,
  input  logic [W-1:0] win_i,
  output logic         active_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (trig_i)      cnt <= (win_i == '0) ? W'(1) : win_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/ctu_downscale.sv
// Passes one pulse in factor_i; 0 and 1 pass every pulse.
module ctu_downscale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pulse_i,
  input  logic [W-1:0] factor_i,
  output logic         pass_o
);
  logic [W-1:0] cnt;
  logic         reach;

  assign reach  = ({1'b0, cnt} + 1'b1) >= {1'b0, factor_i};
  assign pass_o = pulse_i & reach;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (pulse_i)   cnt <= reach ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ctu_readout.sv
// Latches pattern and timestamp on capture, serves tag, pattern, timestamp words.
module ctu_readout #(
  parameter int RD_W  = 16,
  parameter int TS_W  = 48,
  parameter int PAT_W = 3,
  parameter logic [15:0] TAG = 16'h2367
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             next_i,
  output logic [RD_W-1:0]  data_o
);
  localparam int TS_WORDS = TS_W / RD_W;
  localparam int NWORDS   = 2 + TS_WORDS;
  localparam int IDX_W    = $clog2(NWORDS);

  logic [PAT_W-1:0] pat_q;
  logic [TS_W-1:0]  ts_q;
  logic [IDX_W-1:0] idx;
  logic [RD_W-1:0]  words [NWORDS];

  assign words[0] = RD_W'(TAG);
  assign words[1] = RD_W'(pat_q);

  for (genvar k = 0; k < TS_WORDS; k++) begin : g_ts_word
    assign words[2+k] = ts_q[TS_W-1-k*RD_W -: RD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      ts_q   <= '0;
      idx    <= '0;
      data_o <= '0;
    end else begin
      if (capture_i) begin
        pat_q <= pattern_i;
        ts_q  <= ts_i;
        idx   <= '0;
      end else if (next_i && idx < IDX_W'(NWORDS-1)) begin
        idx <= idx + 1'b1;
      end
      data_o <= words[idx];
    end
  end
endmodule

// File: rtl/coinc_trigger_unit.sv
module coinc_trigger_unit
  import ctu_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int DS_W        = 8,
  parameter int TS_W        = 48,
  parameter int RD_W        = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fp_pulse_i,
  input  logic              sec_pulse_i,
  input  logic [NSRC-1:0]   cfg_src_en,
  input  logic [WIN_W-1:0]  cfg_window,
  input  logic [DS_W-1:0]   cfg_downscale,
  input  logic              rd_next_i,
  input  logic              rd_ack_i,
  output logic              raw_trig_o,
  output logic              live_trig_o,
  output logic              busy_o,
  output logic [RD_W-1:0]   rd_data_o,
  output logic [CNT_W-1:0]  cnt_fp_o,
  output logic [CNT_W-1:0]  cnt_sec_o,
  output logic [CNT_W-1:0]  cnt_raw_o
);
  logic fp_rise, sec_rise, ds_pass;
  logic fp_act, sec_act;
  logic ds_q, sec_q, co_q;
  logic co_lvl;
  logic [NSRC-1:0] src, recent, pattern;
  logic raw_next, live_next;
  logic [TS_W-1:0] ts_q;

  ctu_pulse_in #(.STAGES(SYNC_STAGES)) u_fp_in (
    .clk(clk), .rst(rst), .pulse_i(fp_pulse_i), .rise_o(fp_rise));
  ctu_pulse_in #(.STAGES(SYNC_STAGES)) u_sec_in (
    .clk(clk), .rst(rst), .pulse_i(sec_pulse_i), .rise_o(sec_rise));

  ctu_downscale #(.W(DS_W)) u_ds (
    .clk(clk), .rst(rst), .pulse_i(fp_rise), .factor_i(cfg_downscale), .pass_o(ds_pass));

  ctu_stretch #(.W(WIN_W)) u_fp_win (
    .clk(clk), .rst(rst), .trig_i(fp_rise), .win_i(cfg_window), .active_o(fp_act));
  ctu_stretch #(.W(WIN_W)) u_sec_win (
    .clk(clk), .rst(rst), .trig_i(sec_rise), .win_i(cfg_window), .active_o(sec_act));

  // Source pulses, all aligned one cycle after the edge detectors.
  assign co_lvl       = fp_act & sec_act;
  assign src[SRC_DS]  = ds_q;
  assign src[SRC_SEC] = sec_q;
  assign src[SRC_CO]  = co_lvl & ~co_q;

  // Per-source memory of firing within the window before a live trigger.
  for (genvar s = 0; s < NSRC; s++) begin : g_recent
    ctu_stretch #(.W(WIN_W)) u_recent (
      .clk(clk), .rst(rst), .trig_i(src[s]), .win_i(cfg_window), .active_o(recent[s]));
  end

  assign pattern   = src | recent;
  assign raw_next  = |(src & cfg_src_en);
  assign live_next = raw_next & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_q        <= 1'b0;
      sec_q       <= 1'b0;
      co_q        <= 1'b0;
      raw_trig_o  <= 1'b0;
      live_trig_o <= 1'b0;
      busy_o      <= 1'b0;
      ts_q        <= '0;
      cnt_fp_o    <= '0;
      cnt_sec_o   <= '0;
      cnt_raw_o   <= '0;
    end else begin
      ds_q        <= ds_pass;
      sec_q       <= sec_rise;
      co_q        <= co_lvl;
      raw_trig_o  <= raw_next;
      live_trig_o <= live_next;
      if (live_next)     busy_o <= 1'b1;
      else if (rd_ack_i) busy_o <= 1'b0;
      ts_q        <= ts_q + 1'b1;
      cnt_fp_o    <= cnt_fp_o + CNT_W'(fp_rise);
      cnt_sec_o   <= cnt_sec_o + CNT_W'(sec_rise);
      cnt_raw_o   <= cnt_raw_o + CNT_W'(raw_next);
    end
  end

  ctu_readout #(.RD_W(RD_W), .TS_W(TS_W), .PAT_W(NSRC), .TAG(PKT_TAG)) u_rd (
    .clk(clk), .rst(rst), .capture_i(live_next), .pattern_i(pattern),
    .ts_i(ts_q), .next_i(rd_next_i & busy_o), .data_o(rd_data_o));
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
  parameter int NS    = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NS-1:0]    cfg_src_en,
  input logic             rd_ack_i,
  input logic             raw_trig_o,
  input logic             live_trig_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] cnt_raw_o
);
  p_raw_enabled_r1: assert property (@(posedge clk) disable iff (rst)
    raw_trig_o |-> $past(cfg_src_en) != '0);

  p_live_has_raw_r4: assert property (@(posedge clk) disable iff (rst)
    live_trig_o |-> raw_trig_o);

  p_live_idle_r4: assert property (@(posedge clk) disable iff (rst)
    live_trig_o |-> !$past(busy_o));

  p_idle_raw_live_r4: assert property (@(posedge clk) disable iff (rst)
    (raw_trig_o && !$past(busy_o)) |-> live_trig_o);

  p_live_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
    live_trig_o |-> busy_o);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rd_ack_i) |=> busy_o);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && rd_ack_i) |=> !busy_o);

  p_raw_count_r9: assert property (@(posedge clk) disable iff (rst)
    raw_trig_o |-> cnt_raw_o == CNT_W'($past(cnt_raw_o) + 1'b1));

  p_raw_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !raw_trig_o |-> $stable(cnt_raw_o));
endmodule

bind coinc_trigger_unit ctu_checker #(.NS(ctu_pkg::NSRC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_src_en(cfg_src_en), .rd_ack_i(rd_ack_i),
  .raw_trig_o(raw_trig_o), .live_trig_o(live_trig_o), .busy_o(busy_o),
  .cnt_raw_o(cnt_raw_o));

// File: tb/test_coinc_trigger_unit.sv
`timescale 1ns/1ps
module test_coinc_trigger_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fp = 1'b0, sec = 1'b0;
  logic [2:0]  en = 3'b000;
  logic [7:0]  win = 8'd4;
  logic [7:0]  ds = 8'd1;
  logic        rd_next = 1'b0, rd_ack = 1'b0;
  logic        raw, live, busy;
  logic [15:0] rd_data, cnt_fp, cnt_sec, cnt_raw;

  int checks = 0, fails = 0;
  int raw_seen = 0, live_seen = 0;
  longint cyc = 0, live_cyc = 0;
  int nfp = 0, nsec = 0;
  int ds_model = 0;
  logic [15:0] pkt [5];

  always #2.5 clk = ~clk;

  coinc_trigger_unit i_coinc_trigger_unit (
    .clk(clk), .rst(rst), .fp_pulse_i(fp), .sec_pulse_i(sec),
    .cfg_src_en(en), .cfg_window(win), .cfg_downscale(ds),
    .rd_next_i(rd_next), .rd_ack_i(rd_ack),
    .raw_trig_o(raw), .live_trig_o(live), .busy_o(busy), .rd_data_o(rd_data),
    .cnt_fp_o(cnt_fp), .cnt_sec_o(cnt_sec), .cnt_raw_o(cnt_raw));

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (raw) raw_seen++;
    if (live) begin live_seen++; live_cyc = cyc; end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench model of the downscaler rule (R3).
  function automatic bit ds_step(int n);
    if (ds_model + 1 >= n) begin ds_model = 0; return 1'b1; end
    ds_model++;
    return 1'b0;
  endfunction

  task automatic pulse_fp();
    @(negedge clk) fp = 1'b1; @(negedge clk) fp = 1'b0; nfp++;
  endtask

  task automatic pulse_sec();
    @(negedge clk) sec = 1'b1; @(negedge clk) sec = 1'b0; nsec++;
  endtask

  // Two one-cycle pulses, the second starting gap cycles after the first.
  task automatic pair(bit fp_first, int gap);
    @(negedge clk);
    if (fp_first) fp = 1'b1; else sec = 1'b1;
    @(negedge clk) fp = 1'b0; sec = 1'b0;
    repeat (gap - 1) @(negedge clk);
    if (fp_first) sec = 1'b1; else fp = 1'b1;
    @(negedge clk) fp = 1'b0; sec = 1'b0;
    nfp++; nsec++;
  endtask

  task automatic read_pkt();
    for (int i = 0; i < 5; i++) begin
      pkt[i] = rd_data;
      rd_next = 1'b1; @(negedge clk);
      rd_next = 1'b0; @(negedge clk);
    end
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk);
    rd_ack = 1'b0;
  endtask

  function automatic logic [47:0] pkt_ts();
    return {pkt[2], pkt[3], pkt[4]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int r0, l0, exp_raw;
    longint first_cyc;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick(2);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 raw", raw, 0);
    chk("R10 cnt_raw", cnt_raw, 0);
    chk("R10 cnt_fp", cnt_fp, 0);

    // R1: nothing enabled, overlapping pulses
    pair(1'b1, 2); tick(10);
    chk("R1 no raw when disabled", raw_seen, 0);

    // Secondary singles: live trigger and packet
    en = 3'b010;
    pulse_sec(); tick(8);
    chk("R4 live on idle raw", live_seen, 1);
    chk("R4 busy set", busy, 1);
    read_pkt();
    chk("R7 tag word", pkt[0], 16'h2367);
    chk("R6 pattern secondary", pkt[1], 16'h0002);
    chk("R8 timestamp", pkt_ts(), 48'(live_cyc - 1));
    chk("R5 busy before ack", busy, 1);
    ack();
    chk("R5 busy cleared", busy, 0);

    // Coincidence only
    en = 3'b100;
    r0 = raw_seen;
    pulse_fp(); tick(10);
    chk("R2 fp alone", raw_seen, r0);
    pair(1'b1, 10); tick(10);
    chk("R2 out of window", raw_seen, r0);
    pair(1'b1, 2); tick(8);
    chk("R2 overlap fp first", raw_seen, r0 + 1);
    read_pkt();
    chk("R6 pattern coinc fp first", pkt[1], 16'h0007);
    chk("R8 timestamp coinc", pkt_ts(), 48'(live_cyc - 1));
    ack();
    pair(1'b0, 3); tick(8);
    chk("R2 overlap sec first", raw_seen, r0 + 2);
    read_pkt();
    chk("R6 pattern coinc sec first", pkt[1], 16'h0007);
    chk("R7 tag again", pkt[0], 16'h2367);
    ack();

    // R4: raw during busy does not overwrite
    en = 3'b011;
    r0 = raw_seen; l0 = live_seen;
    pulse_sec(); tick(8);
    first_cyc = live_cyc;
    pulse_fp(); tick(8);
    chk("R4 raw during busy", raw_seen, r0 + 2);
    chk("R4 no live during busy", live_seen, l0 + 1);
    read_pkt();
    chk("R4 pattern kept", pkt[1], 16'h0002);
    chk("R4 timestamp kept", pkt_ts(), 48'(first_cyc - 1));
    chk("R7 last word held", rd_data, pkt[4]);
    ack();

    // R3 directed: N=3 from a fresh count (all earlier fp pulses passed with N=1)
    en = 3'b001; ds = 8'd3; ds_model = 0;
    r0 = raw_seen; exp_raw = 0;
    for (int i = 0; i < 6; i++) begin
      if (ds_step(3)) exp_raw++;
      pulse_fp(); tick(2);
    end
    tick(8);
    chk("R3 one in three", raw_seen - r0, exp_raw);
    if (busy) ack();

    // R3 random factors 0..5, carried count
    for (int rnd = 0; rnd < 12; rnd++) begin
      int n, k;
      n = $urandom_range(0, 5);
      k = $urandom_range(1, 9);
      ds = 8'(n);
      tick(2);
      r0 = raw_seen; exp_raw = 0;
      for (int i = 0; i < k; i++) begin
        if (ds_step(n)) exp_raw++;
        pulse_fp(); tick($urandom_range(2, 4));
      end
      tick(8);
      chk($sformatf("R3 factor %0d", n), raw_seen - r0, exp_raw);
      if (busy) ack();
      tick(2);
    end

    // R9 counters
    chk("R9 fp count", cnt_fp, 16'(nfp));
    chk("R9 sec count", cnt_sec, 16'(nsec));
    chk("R9 raw count", cnt_raw, 16'(raw_seen));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule